// File: doc/BRIEF.md
# Shared-Memory Waveform Sequencer

The sequencer plays a stream of output samples described by a list of instruction words. Each instruction points at a waveform segment and says how many times to repeat it. The instructions and the segment samples sit in one memory that is reached through a single read port. A run begins when `start_i` is pulsed with the word address of the first instruction. Several instruction lists can be resident at once, and choosing between them takes only a different base address.

Instructions are read from memory while the output plays, not loaded ahead of time, so a list can be as long as memory allows. A small instruction prefetch FIFO and a sample-word FIFO hide the read latency. Sample reads win the port over instruction reads. Each memory word carries two 16-bit samples. Once output begins, one sample leaves per clock until the list ends. After that the last sample is held and `done_o` is raised. `underflow_o` records any cycle in which generation was running but no sample was ready.

The memory port accepts one request per cycle. It returns read data in request order, any whole number of cycles later.

Top module: `wave_seq_engine`

## Requirements
- R1: After reset, `smp_valid_o`, `done_o`, `busy_o`, `underflow_o` and `mem_req_o` are all low.
- R2: A `start_i` pulse accepted while idle raises `busy_o` from the next cycle. In that same cycle the first memory request reads the word at `base_i`. Later instructions are read from consecutive word addresses.
- R3: An instruction word holds the segment start address in bits [11:0], the segment length minus one (in words) in bits [19:12], the loop count in bits [27:20] and an end flag in bit 31. The segment's words are played in address order. Each word gives bits [15:0] first and then bits [31:16].
- R4: A loop count K plays the segment K times back to back. A loop count of zero plays it once.
- R5: The instruction whose bit 31 is set is the last one played. Instruction words after it have no effect on the output. No memory request is made once its final sample word has been requested.
- R6: With a read latency of 1 to 5 cycles and segments of at least two words, `smp_valid_o` stays high every cycle from the first sample to the last.
- R7: `done_o` rises in the same cycle as the last sample and stays high. `busy_o` is low from then on. After that cycle `smp_valid_o` is low and `smp_o` keeps the last sample.
- R8: `underflow_o` rises if no sample word is buffered during a cycle of active output. It stays high until the next accepted start, which clears it.
- R9: A `start_i` pulse while `busy_o` is high is ignored, and the running list plays unchanged.
- R10: Lists stored at different base addresses can be run one after another, and each replays exactly, without rewriting memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (accepted only when not busy) |
| base_i | input | 12 | Word address of the first instruction |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 12 | Memory read word address |
| mem_rvalid_i | input | 1 | Read data valid, in request order |
| mem_rdata_i | input | 32 | Read data word |
| smp_valid_o | output | 1 | Output sample valid |
| smp_o | output | 16 | Output sample |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last sample emitted; output held |
| underflow_o | output | 1 | Sticky starvation flag for the current run |

## Verification
`busy_o` and the first instruction request are both due one cycle after the clock edge that takes the start pulse, and the bench checks both at the following falling edge. After that the bench collects samples on every falling edge until `done_o`, and checks that this same edge also shows the final valid sample. The stream that was collected is compared with a stream the bench builds by walking the instruction words in its own memory model. Gap-freedom is judged from the first and last valid cycles, not by a predicted start cycle, because the start depends on read latency. The hold, idle and no-request checks are made one falling edge after `done_o`.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int unsigned SMP_W  = 16;
  localparam int unsigned WORD_W = 2 * SMP_W;

  typedef struct packed {
    logic is_instr;
    logic eos;
  } rd_tag_t;

  typedef enum logic [1:0] {
    OUT_IDLE  = 2'd0,
    OUT_PRIME = 2'd1,
    OUT_RUN   = 2'd2,
    OUT_DONE  = 2'd3
  } out_state_e;
endpackage

// File: rtl/wseq_fifo.sv
module wseq_fifo #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic [AW:0]   cnt
);
  localparam int unsigned D = 1 << AW;

  logic [W-1:0] store_q [D];
  logic [AW:0]  wp_q, rp_q, wp_d, rp_d;

  always_comb begin
    wp_d = wp_q + (AW+1)'(push);
    rp_d = rp_q + (AW+1)'(pop);
    if (clr) begin
      wp_d = '0;
      rp_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wp_q[AW-1:0]] <= din;
  end

  assign dout  = store_q[rp_q[AW-1:0]];
  assign cnt   = wp_q - rp_q;
  assign empty = (cnt == '0);

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && push && !pop) |-> (cnt < (AW+1)'(D))); // R6
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && pop) |-> !empty); // R6
endmodule

// File: rtl/wseq_fetch.sv
module wseq_fetch
  import wseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned LOOP_W = 8,
  parameter int unsigned IF_AW  = 2,
  parameter int unsigned SF_AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic [SF_AW:0]    sf_cnt_i,
  output logic              sf_push_o,
  output logic              sf_eos_o,
  output logic              drained_o
);
  localparam int unsigned IF_D    = 1 << IF_AW;
  localparam int unsigned SF_D    = 1 << SF_AW;
  localparam int unsigned IW      = ADDR_W + LEN_W + LOOP_W + 1;
  localparam int unsigned TAG_AW  = ((IF_AW > SF_AW) ? IF_AW : SF_AW) + 1;
  localparam int unsigned LEN_LSB = ADDR_W;
  localparam int unsigned LP_LSB  = ADDR_W + LEN_W;
  localparam int unsigned EOS_BIT = WORD_W - 1;

  // run control
  logic act_q, act_d, end_q, end_d, fin_q, fin_d;
  logic [ADDR_W-1:0] ifa_q, ifa_d;
  logic [IF_AW:0] iout_q, iout_d;
  logic [SF_AW:0] sout_q, sout_d;
  // current segment
  logic              cv_q, cv_d, ceos_q, ceos_d;
  logic [ADDR_W-1:0] cadr_q, cadr_d;
  logic [LEN_W-1:0]  clen_q, clen_d, cidx_q, cidx_d;
  logic [LOOP_W-1:0] cloop_q, cloop_d;

  // instruction prefetch fifo
  logic          if_push, if_pop, if_empty;
  logic [IW-1:0] if_din, if_dout;
  logic [IF_AW:0] if_cnt;
  // read-order tag fifo
  rd_tag_t       tag_din, tag_dout;
  logic          tag_empty;
  logic [TAG_AW:0] tag_cnt;

  logic [IF_AW+1:0] i_sum;
  logic [SF_AW+1:0] s_sum;
  logic i_room, s_room, can_s, can_i, last_word, last_loop, s_fin, seq_end, need_load;
  logic rsp_instr, rsp_smp;
  logic [ADDR_W-1:0] ld_adr;
  logic [LEN_W-1:0]  ld_len;
  logic [LOOP_W-1:0] ld_loop;
  logic              ld_eos;

  wseq_fifo #(.W(IW), .AW(IF_AW)) u_ififo (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .push(if_push), .din(if_din),
    .pop(if_pop), .dout(if_dout), .empty(if_empty), .cnt(if_cnt)
  );

  wseq_fifo #(.W($bits(rd_tag_t)), .AW(TAG_AW)) u_tfifo (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .push(mem_req_o), .din(tag_din),
    .pop(mem_rvalid_i), .dout(tag_dout), .empty(tag_empty), .cnt(tag_cnt)
  );

  always_comb begin
    i_sum     = {1'b0, if_cnt} + {1'b0, iout_q};
    s_sum     = {1'b0, sf_cnt_i} + {1'b0, sout_q};
    i_room    = i_sum < (IF_AW+2)'(IF_D);
    s_room    = s_sum < (SF_AW+2)'(SF_D);
    can_s     = act_q && cv_q && s_room;
    can_i     = act_q && !end_q && !can_s && i_room;
    last_word = (cidx_q == clen_q);
    last_loop = (cloop_q <= LOOP_W'(1));
    s_fin     = can_s && last_word && last_loop;
    seq_end   = s_fin && ceos_q;
    need_load = act_q && !fin_q && (!cv_q || s_fin) && !seq_end && !if_empty;
    if_pop    = need_load;

    mem_req_o  = can_s || can_i;
    mem_addr_o = can_s ? (cadr_q + ADDR_W'(cidx_q)) : ifa_q;
    tag_din.is_instr = can_i;
    tag_din.eos      = seq_end;

    rsp_instr = mem_rvalid_i && tag_dout.is_instr;
    rsp_smp   = mem_rvalid_i && !tag_dout.is_instr;
    if_push   = rsp_instr && !end_q;
    if_din    = {mem_rdata_i[EOS_BIT], mem_rdata_i[LP_LSB +: LOOP_W],
                 mem_rdata_i[LEN_LSB +: LEN_W], mem_rdata_i[ADDR_W-1:0]};
    sf_push_o = rsp_smp;
    sf_eos_o  = tag_dout.eos;
    drained_o = fin_q && (sout_q == '0);

    ld_adr  = if_dout[ADDR_W-1:0];
    ld_len  = if_dout[ADDR_W +: LEN_W];
    ld_loop = if_dout[ADDR_W+LEN_W +: LOOP_W];
    ld_eos  = if_dout[IW-1];
  end

  // next state
  always_comb begin
    act_d = act_q; end_d = end_q; fin_d = fin_q; ifa_d = ifa_q;
    cv_d = cv_q; ceos_d = ceos_q; cadr_d = cadr_q; clen_d = clen_q;
    cidx_d = cidx_q; cloop_d = cloop_q;
    iout_d = iout_q + (IF_AW+1)'(can_i) - (IF_AW+1)'(rsp_instr);
    sout_d = sout_q + (SF_AW+1)'(can_s) - (SF_AW+1)'(rsp_smp);
    if (start_i) begin
      act_d = 1'b1; end_d = 1'b0; fin_d = 1'b0; ifa_d = base_i; cv_d = 1'b0;
    end else begin
      if (can_i) ifa_d = ifa_q + ADDR_W'(1);
      if (if_push && mem_rdata_i[EOS_BIT]) end_d = 1'b1;
      if (can_s) begin
        if (last_word) begin
          cidx_d = '0;
          if (last_loop) begin
            cv_d = 1'b0;
            if (ceos_q) fin_d = 1'b1;
          end else begin
            cloop_d = cloop_q - LOOP_W'(1);
          end
        end else begin
          cidx_d = cidx_q + LEN_W'(1);
        end
      end
      if (need_load) begin
        cv_d    = 1'b1;
        cadr_d  = ld_adr;
        clen_d  = ld_len;
        cidx_d  = '0;
        cloop_d = (ld_loop == '0) ? LOOP_W'(1) : ld_loop;
        ceos_d  = ld_eos;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; end_q <= 1'b0; fin_q <= 1'b0; ifa_q <= '0;
      iout_q <= '0; sout_q <= '0;
      cv_q <= 1'b0; ceos_q <= 1'b0; cadr_q <= '0; clen_q <= '0;
      cidx_q <= '0; cloop_q <= '0;
    end else begin
      act_q <= act_d; end_q <= end_d; fin_q <= fin_d; ifa_q <= ifa_d;
      iout_q <= iout_d; sout_q <= sout_d;
      cv_q <= cv_d; ceos_q <= ceos_d; cadr_q <= cadr_d; clen_q <= clen_d;
      cidx_q <= cidx_d; cloop_q <= cloop_d;
    end
  end

  AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid_i |-> (!tag_empty && tag_cnt != '0)); // R2
  AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && !start_i) |-> !mem_req_o); // R5
  AST_SMP_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    s_sum <= (SF_AW+2)'(SF_D)); // R6
endmodule

// File: rtl/wseq_out.sv
module wseq_out
  import wseq_pkg::*;
#(
  parameter int unsigned SF_AW   = 3,
  parameter int unsigned PRIME_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sf_empty_i,
  input  logic [SF_AW:0]    sf_cnt_i,
  input  logic [WORD_W-1:0] sf_word_i,
  input  logic              sf_eos_i,
  input  logic              drained_i,
  output logic              sf_pop_o,
  output logic              smp_valid_o,
  output logic [SMP_W-1:0]  smp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              underflow_o
);
  out_state_e st_q, st_d;
  logic half_q, half_d, vld_q, vld_d, done_q, done_d, und_q, und_d, smp_en;
  logic [SMP_W-1:0] smp_q, smp_d;

  always_comb begin
    st_d = st_q; half_d = half_q; vld_d = 1'b0; done_d = done_q; und_d = und_q;
    smp_d = smp_q; smp_en = 1'b0; sf_pop_o = 1'b0;
    if (start_i) begin
      st_d = OUT_PRIME; half_d = 1'b0; done_d = 1'b0; und_d = 1'b0;
    end else begin
      unique case (st_q)
        OUT_PRIME: begin
          if (sf_cnt_i >= (SF_AW+1)'(PRIME_W) || (drained_i && !sf_empty_i))
            st_d = OUT_RUN;
        end
        OUT_RUN: begin
          if (!sf_empty_i) begin
            vld_d  = 1'b1;
            smp_en = 1'b1;
            smp_d  = half_q ? sf_word_i[WORD_W-1:SMP_W] : sf_word_i[SMP_W-1:0];
            half_d = !half_q;
            if (half_q) begin
              sf_pop_o = 1'b1;
              if (sf_eos_i) begin
                st_d   = OUT_DONE;
                done_d = 1'b1;
              end
            end
          end else begin
            und_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= OUT_IDLE; half_q <= 1'b0; vld_q <= 1'b0; done_q <= 1'b0; und_q <= 1'b0;
    end else begin
      st_q <= st_d; half_q <= half_d; vld_q <= vld_d; done_q <= done_d; und_q <= und_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      smp_q <= '0;
    else if (smp_en) smp_q <= smp_d;
  end

  assign smp_valid_o = vld_q;
  assign smp_o       = smp_q;
  assign done_o      = done_q;
  assign underflow_o = und_q;
  assign busy_o      = (st_q == OUT_PRIME) || (st_q == OUT_RUN);

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |-> !smp_valid_o); // R1
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R7
  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> (!smp_valid_o && $stable(smp_o))); // R7
  AST_GAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(smp_valid_o) && !smp_valid_o && !done_o) |-> underflow_o); // R8
endmodule

// File: rtl/wave_seq_engine.sv
module wave_seq_engine
  import wseq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned LOOP_W  = 8,
  parameter int unsigned IF_AW   = 2,
  parameter int unsigned SF_AW   = 3,
  parameter int unsigned PRIME_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              smp_valid_o,
  output logic [15:0]       smp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              underflow_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  logic       start_ok;
  logic       sf_push, sf_eos, sf_pop, sf_empty, drained;
  logic [WORD_W:0] sf_dout;
  logic [SF_AW:0]  sf_cnt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn   = rst_sync_q[1];
  assign start_ok = start_i && !busy_o;

  wseq_fetch #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LOOP_W(LOOP_W), .IF_AW(IF_AW), .SF_AW(SF_AW)
  ) u_fetch (
    .clk(clk), .rst_n(rst_sn), .start_i(start_ok), .base_i(base_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .sf_cnt_i(sf_cnt), .sf_push_o(sf_push), .sf_eos_o(sf_eos), .drained_o(drained)
  );

  wseq_fifo #(.W(WORD_W+1), .AW(SF_AW)) u_sfifo (
    .clk(clk), .rst_n(rst_sn), .clr(start_ok), .push(sf_push),
    .din({sf_eos, mem_rdata_i}), .pop(sf_pop), .dout(sf_dout),
    .empty(sf_empty), .cnt(sf_cnt)
  );

  wseq_out #(.SF_AW(SF_AW), .PRIME_W(PRIME_W)) u_out (
    .clk(clk), .rst_n(rst_sn), .start_i(start_ok),
    .sf_empty_i(sf_empty), .sf_cnt_i(sf_cnt), .sf_word_i(sf_dout[WORD_W-1:0]),
    .sf_eos_i(sf_dout[WORD_W]), .drained_i(drained), .sf_pop_o(sf_pop),
    .smp_valid_o(smp_valid_o), .smp_o(smp_o), .busy_o(busy_o),
    .done_o(done_o), .underflow_o(underflow_o)
  );

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_sn)
    (start_i && busy_o && !done_o) |=> !done_o || smp_valid_o); // R9
endmodule

// File: tb/tb_wave_seq_engine.sv
module tb_wave_seq_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] base_i = '0;
  logic        mem_req_o;
  logic [11:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        smp_valid_o;
  logic [15:0] smp_o;
  logic        busy_o, done_o, underflow_o;

  always #5 clk = ~clk;

  wave_seq_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .smp_valid_o(smp_valid_o), .smp_o(smp_o), .busy_o(busy_o),
    .done_o(done_o), .underflow_o(underflow_o)
  );

  // memory model: in-order responses after lat cycles
  logic [31:0] mem [1024];
  logic        pv [32];
  logic [31:0] pd [32];
  int ph = 0;
  int lat = 2;

  always @(posedge clk) begin
    mem_rvalid_i <= pv[ph];
    mem_rdata_i  <= pd[ph];
    pv[ph] <= 1'b0;
    if (mem_req_o) begin
      pv[(ph + lat) % 32] <= 1'b1;
      pd[(ph + lat) % 32] <= mem[mem_addr_o[9:0]];
    end
    ph <= (ph + 1) % 32;
  end

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R6 watchdog: cycles=%0d expected below %0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int a, input int lm1, input int lp, input bit eos);
    return {eos, 3'b000, 8'(lp), 8'(lm1), 12'(a)};
  endfunction

  int exp_q[$];
  int got_q[$];
  int a_first[$];

  // expected stream from the instruction format of R3/R4/R5
  task automatic build(input int base);
    int a;
    exp_q.delete();
    a = base;
    for (int g = 0; g < 64; g++) begin
      logic [31:0] w;
      int k;
      w = mem[a % 1024];
      k = (w[27:20] == 0) ? 1 : int'(w[27:20]);
      for (int r = 0; r < k; r++) begin
        for (int i = 0; i <= int'(w[19:12]); i++) begin
          logic [31:0] d;
          d = mem[(int'(w[11:0]) + i) % 1024];
          exp_q.push_back(int'(d[15:0]));
          exp_q.push_back(int'(d[31:16]));
        end
      end
      if (w[31]) break;
      a++;
    end
  endtask

  task automatic run(input int base, input int l, input bit poke, input int poke_base,
                     input bit exp_und, input string nm);
    int first_v, last_v, bad;
    bit saw_done, done_with_last;
    @(negedge clk);
    lat = l;
    base_i = 12'(base);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, {nm, " R2 busy after start"}, busy_o, 1);
    chk(mem_req_o === 1'b1 && mem_addr_o == 12'(base), {nm, " R2 first fetch address"},
        mem_addr_o, base);
    got_q.delete();
    first_v = -1; last_v = -1; saw_done = 0; done_with_last = 0;
    for (int n = 0; n < 4000 && !saw_done; n++) begin
      if (poke && n == 6) begin start_i = 1'b1; base_i = 12'(poke_base); end
      if (poke && n == 7) start_i = 1'b0;
      if (smp_valid_o) begin
        if (first_v < 0) first_v = n;
        last_v = n;
        got_q.push_back(int'(smp_o));
      end
      if (done_o) begin
        saw_done = 1;
        done_with_last = smp_valid_o;
      end else begin
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    chk(saw_done, {nm, " R7 done reached"}, saw_done, 1);
    chk(done_with_last, {nm, " R7 done with last sample"}, done_with_last, 1);
    build(base);
    chk(got_q.size() == exp_q.size(), {nm, " R4 R5 sample count"}, got_q.size(), exp_q.size());
    bad = -1;
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
    chk(bad < 0, {nm, " R3 sample content"}, (bad < 0) ? 0 : got_q[bad],
        (bad < 0) ? 0 : exp_q[bad]);
    if (!exp_und)
      chk(last_v - first_v + 1 == got_q.size(), {nm, " R6 gapless span"},
          last_v - first_v + 1, got_q.size());
    chk(underflow_o === exp_und, {nm, " R8 underflow flag"}, underflow_o, exp_und);
    @(negedge clk);
    chk(!smp_valid_o && done_o && !busy_o, {nm, " R7 idle after done"},
        {smp_valid_o, done_o, busy_o}, 3'b010);
    if (got_q.size() > 0)
      chk(int'(smp_o) == got_q[got_q.size()-1], {nm, " R7 last sample held"},
          smp_o, got_q[got_q.size()-1]);
    chk(!mem_req_o, {nm, " R5 no request after end"}, mem_req_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin pv[i] = 1'b0; pd[i] = '0; end
    for (int a = 0; a < 1024; a++) mem[a] = {16'(a) | 16'h8000, 16'(a) ^ 16'h0F0F};
    // list A at 512, with a stray instruction after its end (R5)
    mem[512] = mk(100, 1, 0, 0);
    mem[513] = mk(200, 2, 2, 0);
    mem[514] = mk(300, 3, 3, 1);
    mem[515] = mk(400, 7, 5, 0);
    // list B at 520
    mem[520] = mk(400, 7, 1, 1);
    // list D at 540, long, for the starvation case
    mem[540] = mk(600, 7, 4, 1);

    repeat (3) @(negedge clk);
    chk(!smp_valid_o && !done_o && !busy_o && !underflow_o && !mem_req_o,
        "R1 outputs in reset", {smp_valid_o, done_o, busy_o, underflow_o, mem_req_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!smp_valid_o && !done_o && !busy_o && !underflow_o && !mem_req_o,
        "R1 outputs after reset", {smp_valid_o, done_o, busy_o, underflow_o, mem_req_o}, 0);

    run(512, 2, 0, 0, 0, "listA");
    a_first = got_q;
    run(520, 3, 0, 0, 0, "listB");
    run(512, 2, 0, 0, 0, "listA2");
    chk(got_q == a_first, "R10 list A replays after switching", got_q.size(), a_first.size());

    // start while busy is ignored (R9)
    run(512, 4, 1, 520, 0, "R9 poke");

    // starvation with long latency, then recovery (R8)
    run(540, 24, 0, 0, 1, "slowmem");
    run(520, 2, 0, 0, 0, "recover");

    // sweep of segment length, loop count and latency (R3 R4 R6)
    for (int lm = 1; lm <= 3; lm++)
      for (int lp = 0; lp <= 3; lp++)
        for (int li = 0; li < 3; li++) begin
          mem[530] = mk(16, lm, lp, 0);
          mem[531] = mk(40, 1, 1, 1);
          run(530, 1 + 2 * li, 0, 0, 0, $sformatf("sweep l%0d k%0d t%0d", lm, lp, 1 + 2 * li));
        end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule